// File: doc/BRIEF.md
# Lifecycle transition sequencer

This block drives one change of a device's lifecycle state from start to finish. After reset it settles in an idle state and waits. A transition request sends it along a fixed chain of steps. It switches the clock source, checks and then programs the transition counter, and checks that the transition is legal. It then has the presented token hashed, optionally wipes flash for a return-to-manufacturer move, and compares the hashed token against the stored reference in two separate halves. Last, it has the new state programmed. Each step that depends on an outside agent uses a request/acknowledge pair with an error flag. Every failing step lands in a sticky post-transition state and records a result code. An idle device can also be sent straight to a scrapped state.

Two independent escalation inputs override everything and force a terminal escalation state from any state. The state register holds a sparse, parity-protected code. Any value outside the legal code set is reported as a fatal state error and drives the machine into an invalid state. A fault-injection input XORs a mask into the captured code, so that this path can be exercised. Reset is expected to arrive already synchronised to the clock.

Top module: `lcx_transition_fsm`

## Requirements
- R1: While reset is low, state_o reads Reset (index 1), status_o reads 0 and all request outputs are low. On the first clock edge after release the machine moves from Reset to Idle (index 2).
- R2: In Idle, scrap_req_i moves the machine to Scrap (13) and takes priority over trans_req_i. trans_req_i alone moves it to ClkMux (3). With neither request, Idle holds.
- R3: The state indices are ClkMux 3, CntIncr 4, CntProg 5, TransCheck 6, TokenHash 7, FlashRma 8, TokenCheck0 9, TokenCheck1 10 and TransProg 11, and the success path visits them in that order. ClkMux lasts exactly one cycle. clk_byp_o is high exactly in states 3 to 11. cnt_req_o, hash_req_o and prog_req_o are high exactly in states 5, 7 and 11. A handshake state holds until its acknowledge arrives.
- R4: CntIncr with cnt_full_i high, or CntProg acknowledged with cnt_err_i high, moves to PostTrans (12) with status 3.
- R5: TransCheck with trans_legal_i low moves to PostTrans with status 5. Otherwise it moves on to TokenHash after one cycle.
- R6: TokenHash acknowledged with hash_err_i high moves to PostTrans with status 2. A clean acknowledge captures hash_val_i. FlashRma with rma_i low passes to TokenCheck0 in one cycle and leaves flash_req_o low. With rma_i high it raises flash_req_o and waits for flash_ack_i. A flash error is remembered, and TokenCheck0 then ends in PostTrans with status 4.
- R7: TokenCheck0 compares the lower half of the captured hash with ref_token_i, and TokenCheck1 compares the upper half. Each takes exactly one cycle. A mismatch gives PostTrans with status 2, and a TokenCheck1 match gives TransProg.
- R8: TransProg acknowledged with prog_err_i high gives PostTrans with status 6. A clean acknowledge gives PostTrans with status 1.
- R9: PostTrans, Scrap, Escalate (14) and Invalid (15) are held until reset unless escalation applies.
- R10: esc0_i or esc1_i high at a clock edge moves the machine to Escalate from any state, and the status is left unchanged.
- R11: The register code is the 4-bit state index followed by three parity bits (index bits 1^2^3, 0^2^3, 0^1^3), and index 0 is illegal. A single-bit fault makes state_o read 15 and state_err_o go high in the cycle that follows. The machine then stays Invalid unless escalation applies.
- R12: status_o codes are 0 none, 1 success, 2 token error, 3 counter error, 4 flash error, 5 transition-check error and 6 programming error. It changes only when PostTrans is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| esc0_i | input | 1 | Escalation input A |
| esc1_i | input | 1 | Escalation input B |
| trans_req_i | input | 1 | Start a transition from Idle |
| scrap_req_i | input | 1 | Go directly from Idle to Scrap |
| rma_i | input | 1 | Target needs flash wipe |
| cnt_full_i | input | 1 | Transition counter exhausted |
| trans_legal_i | input | 1 | Requested transition is legal |
| cnt_req_o | output | 1 | Counter program request |
| cnt_ack_i | input | 1 | Counter program acknowledge |
| cnt_err_i | input | 1 | Counter program error |
| hash_req_o | output | 1 | Token hash request |
| hash_ack_i | input | 1 | Token hash acknowledge |
| hash_err_i | input | 1 | Token hash error |
| hash_val_i | input | TOKEN_W | Hashed token |
| ref_token_i | input | TOKEN_W | Stored reference hash |
| flash_req_o | output | 1 | Flash wipe request |
| flash_ack_i | input | 1 | Flash wipe acknowledge |
| flash_err_i | input | 1 | Flash wipe error |
| prog_req_o | output | 1 | State program request |
| prog_ack_i | input | 1 | State program acknowledge |
| prog_err_i | input | 1 | State program error |
| fault_flip_i | input | 7 | Fault mask XORed into the captured state code |
| clk_byp_o | output | 1 | Clock switched for transition |
| state_o | output | 4 | Decoded state index |
| status_o | output | 3 | Result of the attempt |
| state_err_o | output | 1 | Fatal state encoding error |

## Verification
The bench builds the block with TOKEN_W set to 16, so each compared half of the token is 8 bits. Flipping one bit in one half then isolates the TokenCheck0 and TokenCheck1 failure arcs in directed runs. The narrow token also lets randomly chosen mismatches land on either half. Both escalation inputs and single-bit faults are injected at random and at fixed points, which brings escalation from terminal and invalid states within reach.

// File: rtl/lcx_pkg.sv
package lcx_pkg;
  localparam int IDX_W  = 4;
  localparam int PAR_W  = 3;
  localparam int CODE_W = IDX_W + PAR_W;

  typedef enum logic [IDX_W-1:0] {
    ST_RESET     = 4'd1,
    ST_IDLE      = 4'd2,
    ST_CLKMUX    = 4'd3,
    ST_CNTINCR   = 4'd4,
    ST_CNTPROG   = 4'd5,
    ST_TRANSCHK  = 4'd6,
    ST_TOKHASH   = 4'd7,
    ST_FLASHRMA  = 4'd8,
    ST_TOKCHK0   = 4'd9,
    ST_TOKCHK1   = 4'd10,
    ST_TRANSPROG = 4'd11,
    ST_POST      = 4'd12,
    ST_SCRAP     = 4'd13,
    ST_ESCALATE  = 4'd14,
    ST_INVALID   = 4'd15
  } lcx_state_e;

  typedef enum logic [2:0] {
    RS_NONE  = 3'd0,
    RS_OK    = 3'd1,
    RS_TOKEN = 3'd2,
    RS_CNT   = 3'd3,
    RS_FLASH = 3'd4,
    RS_CHECK = 3'd5,
    RS_PROG  = 3'd6
  } lcx_status_e;

  function automatic logic [PAR_W-1:0] lcx_parity(input logic [IDX_W-1:0] d);
    return {d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
  endfunction

  function automatic logic [CODE_W-1:0] lcx_encode(input lcx_state_e s);
    return {s, lcx_parity(s)};
  endfunction
endpackage

// File: rtl/lcx_state_reg.sv
module lcx_state_reg
  import lcx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lcx_state_e        nxt_i,
  input  logic [CODE_W-1:0] flip_i,
  output lcx_state_e        state_o,
  output logic              illegal_o
);
  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  idx;
  logic [PAR_W-1:0]  par;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= lcx_encode(ST_RESET);
    else         code_q <= lcx_encode(nxt_i) ^ flip_i;
  end

  assign idx       = code_q[CODE_W-1:PAR_W];
  assign par       = code_q[PAR_W-1:0];
  assign illegal_o = (par != lcx_parity(idx)) || (idx == '0);
  assign state_o   = illegal_o ? ST_INVALID : lcx_state_e'(idx);

  // R11
  onebit_detect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(flip_i) == 1) |=> illegal_o);
endmodule

// File: rtl/lcx_next_state.sv
module lcx_next_state
  import lcx_pkg::*;
(
  input  lcx_state_e  state_i,
  input  logic        illegal_i,
  input  logic        esc_i,
  input  logic        trans_req_i,
  input  logic        scrap_req_i,
  input  logic        rma_i,
  input  logic        cnt_full_i,
  input  logic        trans_legal_i,
  input  logic        cnt_ack_i,
  input  logic        cnt_err_i,
  input  logic        hash_ack_i,
  input  logic        hash_err_i,
  input  logic        flash_ack_i,
  input  logic        flash_err_i,
  input  logic        flash_fail_q_i,
  input  logic        match_lo_i,
  input  logic        match_hi_i,
  input  logic        prog_ack_i,
  input  logic        prog_err_i,
  output lcx_state_e  nxt_o,
  output logic        rec_en_o,
  output lcx_status_e rec_val_o,
  output logic        flash_fail_set_o
);
  always_comb begin
    nxt_o            = state_i;
    rec_en_o         = 1'b0;
    rec_val_o        = RS_NONE;
    flash_fail_set_o = 1'b0;
    case (state_i)
      ST_RESET:  nxt_o = ST_IDLE;
      ST_IDLE: begin
        if (scrap_req_i)      nxt_o = ST_SCRAP;
        else if (trans_req_i) nxt_o = ST_CLKMUX;
      end
      ST_CLKMUX: nxt_o = ST_CNTINCR;
      ST_CNTINCR: begin
        if (cnt_full_i) begin
          nxt_o = ST_POST; rec_en_o = 1'b1; rec_val_o = RS_CNT;
        end else begin
          nxt_o = ST_CNTPROG;
        end
      end
      ST_CNTPROG: begin
        if (cnt_ack_i) begin
          if (cnt_err_i) begin
            nxt_o = ST_POST; rec_en_o = 1'b1; rec_val_o = RS_CNT;
          end else begin
            nxt_o = ST_TRANSCHK;
          end
        end
      end
      ST_TRANSCHK: begin
        if (trans_legal_i) nxt_o = ST_TOKHASH;
        else begin
          nxt_o = ST_POST; rec_en_o = 1'b1; rec_val_o = RS_CHECK;
        end
      end
      ST_TOKHASH: begin
        if (hash_ack_i) begin
          if (hash_err_i) begin
            nxt_o = ST_POST; rec_en_o = 1'b1; rec_val_o = RS_TOKEN;
          end else begin
            nxt_o = ST_FLASHRMA;
          end
        end
      end
      ST_FLASHRMA: begin
        if (!rma_i) nxt_o = ST_TOKCHK0;
        else if (flash_ack_i) begin
          flash_fail_set_o = flash_err_i;
          nxt_o            = ST_TOKCHK0;
        end
      end
      ST_TOKCHK0: begin
        if (flash_fail_q_i) begin
          nxt_o = ST_POST; rec_en_o = 1'b1; rec_val_o = RS_FLASH;
        end else if (!match_lo_i) begin
          nxt_o = ST_POST; rec_en_o = 1'b1; rec_val_o = RS_TOKEN;
        end else begin
          nxt_o = ST_TOKCHK1;
        end
      end
      ST_TOKCHK1: begin
        if (match_hi_i) nxt_o = ST_TRANSPROG;
        else begin
          nxt_o = ST_POST; rec_en_o = 1'b1; rec_val_o = RS_TOKEN;
        end
      end
      ST_TRANSPROG: begin
        if (prog_ack_i) begin
          nxt_o     = ST_POST;
          rec_en_o  = 1'b1;
          rec_val_o = prog_err_i ? RS_PROG : RS_OK;
        end
      end
      ST_POST, ST_SCRAP, ST_ESCALATE, ST_INVALID: nxt_o = state_i;
      default: nxt_o = ST_INVALID;
    endcase

    if (illegal_i) begin
      nxt_o            = ST_INVALID;
      rec_en_o         = 1'b0;
      flash_fail_set_o = 1'b0;
    end
    if (esc_i) begin
      nxt_o            = ST_ESCALATE;
      rec_en_o         = 1'b0;
      flash_fail_set_o = 1'b0;
    end
  end
endmodule

// File: rtl/lcx_token_cmp.sv
module lcx_token_cmp #(
  parameter int TOKEN_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_en_i,
  input  logic [TOKEN_W-1:0] hash_val_i,
  input  logic [TOKEN_W-1:0] ref_i,
  output logic               match_lo_o,
  output logic               match_hi_o
);
  localparam int HALF_W = TOKEN_W / 2;

  logic [TOKEN_W-1:0] hash_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hash_q <= '0;
    else if (cap_en_i) hash_q <= hash_val_i;
  end

  assign match_lo_o = (hash_q[HALF_W-1:0] == ref_i[HALF_W-1:0]);
  assign match_hi_o = (hash_q[TOKEN_W-1:HALF_W] == ref_i[TOKEN_W-1:HALF_W]);
endmodule

// File: rtl/lcx_status_reg.sv
module lcx_status_reg
  import lcx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rec_en_i,
  input  lcx_status_e rec_val_i,
  input  logic        flash_fail_set_i,
  output lcx_status_e status_o,
  output logic        flash_fail_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       status_o <= RS_NONE;
    else if (rec_en_i) status_o <= rec_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flash_fail_q_o <= 1'b0;
    else if (flash_fail_set_i) flash_fail_q_o <= 1'b1;
  end
endmodule

// File: rtl/lcx_transition_fsm.sv
module lcx_transition_fsm
  import lcx_pkg::*;
#(
  parameter int TOKEN_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               esc0_i,
  input  logic               esc1_i,
  input  logic               trans_req_i,
  input  logic               scrap_req_i,
  input  logic               rma_i,
  input  logic               cnt_full_i,
  input  logic               trans_legal_i,
  output logic               cnt_req_o,
  input  logic               cnt_ack_i,
  input  logic               cnt_err_i,
  output logic               hash_req_o,
  input  logic               hash_ack_i,
  input  logic               hash_err_i,
  input  logic [TOKEN_W-1:0] hash_val_i,
  input  logic [TOKEN_W-1:0] ref_token_i,
  output logic               flash_req_o,
  input  logic               flash_ack_i,
  input  logic               flash_err_i,
  output logic               prog_req_o,
  input  logic               prog_ack_i,
  input  logic               prog_err_i,
  input  logic [6:0]         fault_flip_i,
  output logic               clk_byp_o,
  output logic [3:0]         state_o,
  output logic [2:0]         status_o,
  output logic               state_err_o
);
  lcx_state_e  state, nxt;
  logic        illegal, esc;
  logic        rec_en, ff_set, ff_q;
  lcx_status_e rec_val, status;
  logic        match_lo, match_hi, cap_en;

  assign esc    = esc0_i | esc1_i;
  assign cap_en = (state == ST_TOKHASH) && hash_ack_i;

  lcx_state_reg u_state_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nxt_i     (nxt),
    .flip_i    (fault_flip_i),
    .state_o   (state),
    .illegal_o (illegal)
  );

  lcx_next_state u_next_state (
    .state_i          (state),
    .illegal_i        (illegal),
    .esc_i            (esc),
    .trans_req_i      (trans_req_i),
    .scrap_req_i      (scrap_req_i),
    .rma_i            (rma_i),
    .cnt_full_i       (cnt_full_i),
    .trans_legal_i    (trans_legal_i),
    .cnt_ack_i        (cnt_ack_i),
    .cnt_err_i        (cnt_err_i),
    .hash_ack_i       (hash_ack_i),
    .hash_err_i       (hash_err_i),
    .flash_ack_i      (flash_ack_i),
    .flash_err_i      (flash_err_i),
    .flash_fail_q_i   (ff_q),
    .match_lo_i       (match_lo),
    .match_hi_i       (match_hi),
    .prog_ack_i       (prog_ack_i),
    .prog_err_i       (prog_err_i),
    .nxt_o            (nxt),
    .rec_en_o         (rec_en),
    .rec_val_o        (rec_val),
    .flash_fail_set_o (ff_set)
  );

  lcx_token_cmp #(.TOKEN_W(TOKEN_W)) u_token_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   (cap_en),
    .hash_val_i (hash_val_i),
    .ref_i      (ref_token_i),
    .match_lo_o (match_lo),
    .match_hi_o (match_hi)
  );

  lcx_status_reg u_status_reg (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .rec_en_i         (rec_en),
    .rec_val_i        (rec_val),
    .flash_fail_set_i (ff_set),
    .status_o         (status),
    .flash_fail_q_o   (ff_q)
  );

  assign cnt_req_o   = (state == ST_CNTPROG);
  assign hash_req_o  = (state == ST_TOKHASH);
  assign flash_req_o = (state == ST_FLASHRMA) && rma_i;
  assign prog_req_o  = (state == ST_TRANSPROG);
  assign clk_byp_o   = (state >= ST_CLKMUX) && (state <= ST_TRANSPROG);
  assign state_o     = state;
  assign status_o    = status;
  assign state_err_o = (state == ST_INVALID);

  // R1
  reset_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RESET && !esc && fault_flip_i == '0) |=> (state == ST_IDLE));
  // R3
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cnt_req_o, hash_req_o, flash_req_o, prog_req_o}));
  // R7
  tc1_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TOKCHK1) |=> (state != ST_TOKCHK1));
  // R8
  prog_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TRANSPROG && prog_ack_i && !prog_err_i && !esc && fault_flip_i == '0)
    |=> (state == ST_POST && status == RS_OK));
  // R9
  terminal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_POST || state == ST_SCRAP) && !esc && fault_flip_i == '0) |=> $stable(state));
  // R10
  esc_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc && fault_flip_i == '0) |=> (state == ST_ESCALATE));
  // R12
  status_on_post_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(status) && !illegal) |-> (state == ST_POST));
endmodule

// File: tb/lcx_transition_fsm_bench.sv
`timescale 1ns/1ps
module lcx_transition_fsm_bench;
  localparam int TW = 16;
  localparam int HW = TW / 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, esc0, esc1, treq, sreq, rma, full, legal;
  logic cnt_req, cnt_ack, cnt_err, hash_req, hash_ack, hash_err;
  logic flash_req, flash_ack, flash_err, prog_req, prog_ack, prog_err;
  logic [TW-1:0] hval, rtok;
  logic [6:0] flip;
  logic clk_byp, state_err;
  logic [3:0] state;
  logic [2:0] status;

  lcx_transition_fsm #(.TOKEN_W(TW)) u_lcx_transition_fsm (
    .clk_i(clk), .rst_ni(rst_n), .esc0_i(esc0), .esc1_i(esc1),
    .trans_req_i(treq), .scrap_req_i(sreq), .rma_i(rma),
    .cnt_full_i(full), .trans_legal_i(legal),
    .cnt_req_o(cnt_req), .cnt_ack_i(cnt_ack), .cnt_err_i(cnt_err),
    .hash_req_o(hash_req), .hash_ack_i(hash_ack), .hash_err_i(hash_err),
    .hash_val_i(hval), .ref_token_i(rtok),
    .flash_req_o(flash_req), .flash_ack_i(flash_ack), .flash_err_i(flash_err),
    .prog_req_o(prog_req), .prog_ack_i(prog_ack), .prog_err_i(prog_err),
    .fault_flip_i(flip), .clk_byp_o(clk_byp), .state_o(state),
    .status_o(status), .state_err_o(state_err)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // stimulus knobs
  int k_esc, k_flip, k_err, k_ferr, k_perr, k_full, k_ill, k_scrap, k_miss, k_hmode;
  int k_esc_at, k_flip_at;
  bit k_rma;

  int exp_st, exp_status, exp_ff;
  logic [TW-1:0] exp_hash;
  string last_tag;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int s);
    case (s)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4, 5: return "R4";
      6: return "R5";
      7, 8: return "R6";
      9, 10: return "R7";
      11: return "R8";
      15: return "R11";
      default: return "R9";
    endcase
  endfunction

  function automatic int exp_reqs(input int s);
    return {(s >= 3 && s <= 11), s == 5, s == 7, (s == 8) && k_rma, s == 11};
  endfunction

  task automatic knobs_default();
    k_esc = 0; k_flip = 0; k_err = 0; k_ferr = 0; k_perr = 0; k_full = 0;
    k_ill = 0; k_scrap = 0; k_miss = 0; k_hmode = 3; k_esc_at = -1; k_flip_at = -1;
    k_rma = 1'b1;
  endtask

  task automatic drive_idle();
    esc0 = 0; esc1 = 0; treq = 0; sreq = 0; full = 0; legal = 1;
    cnt_ack = 0; cnt_err = 0; hash_ack = 0; hash_err = 0; hval = '0;
    flash_ack = 0; flash_err = 0; prog_ack = 0; prog_err = 0; flip = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive_idle();
    rma  = k_rma;
    rtok = TW'($urandom);
    repeat (2) @(negedge clk);
    chk("R1 reset state", state, 1);
    chk("R1 reset status", status, 0);
    chk("R1 reset requests", {clk_byp, cnt_req, hash_req, flash_req, prog_req}, 0);
    rst_n = 1'b1;
    exp_st = 1; exp_status = 0; exp_ff = 0; exp_hash = '0; last_tag = "R1";
  endtask

  // observe, then drive, then advance the model; called just after a negedge
  task automatic step(input int idx);
    int n, rec, nff, r;
    chk({last_tag, " state"}, state, exp_st);
    chk("R12 status", status, exp_status);
    chk("R11 state_err", state_err, exp_st == 15);
    chk("R3 request outputs", {clk_byp, cnt_req, hash_req, flash_req, prog_req}, exp_reqs(exp_st));

    esc0  = (idx == k_esc_at) || (($urandom % 1000) < k_esc);
    esc1  = (($urandom % 1000) < k_esc);
    flip  = ((idx == k_flip_at) || (($urandom % 1000) < k_flip)) ? 7'(1 << ($urandom % 7)) : 7'd0;
    treq  = $urandom % 2;
    sreq  = ($urandom % 100) < k_scrap;
    full  = ($urandom % 100) < k_full;
    legal = !(($urandom % 100) < k_ill);
    cnt_ack   = cnt_req && ($urandom % 3 == 0);
    cnt_err   = ($urandom % 100) < k_err;
    hash_ack  = hash_req && ($urandom % 3 == 0);
    hash_err  = ($urandom % 100) < k_err;
    flash_ack = flash_req && ($urandom % 3 == 0);
    flash_err = ($urandom % 100) < k_ferr;
    prog_ack  = prog_req && ($urandom % 3 == 0);
    prog_err  = ($urandom % 100) < k_perr;
    r = (k_hmode == 0) ? ((($urandom % 100) < k_miss) ? 1 + int'($urandom % 2) : 3) : k_hmode;
    hval = rtok;
    if (r == 1) hval[$urandom % HW] ^= 1'b1;
    if (r == 2) hval[HW + ($urandom % HW)] ^= 1'b1;

    n = exp_st; rec = -1; nff = 0;
    case (exp_st)
      1: n = 2;
      2: if (sreq) n = 13; else if (treq) n = 3;
      3: n = 4;
      4: if (full) begin n = 12; rec = 3; end else n = 5;
      5: if (cnt_ack) begin if (cnt_err) begin n = 12; rec = 3; end else n = 6; end
      6: if (legal) n = 7; else begin n = 12; rec = 5; end
      7: if (hash_ack) begin if (hash_err) begin n = 12; rec = 2; end else n = 8; end
      8: if (!k_rma) n = 9; else if (flash_ack) begin nff = flash_err; n = 9; end
      9: if (exp_ff != 0) begin n = 12; rec = 4; end
         else if (exp_hash[HW-1:0] != rtok[HW-1:0]) begin n = 12; rec = 2; end
         else n = 10;
      10: if (exp_hash[TW-1:HW] == rtok[TW-1:HW]) n = 11; else begin n = 12; rec = 2; end
      11: if (prog_ack) begin n = 12; rec = prog_err ? 6 : 1; end
      default: n = exp_st;
    endcase
    last_tag = tag_of(exp_st);
    if (exp_st == 7 && hash_ack) exp_hash = hval;
    if (esc0 || esc1) begin n = 14; rec = -1; nff = 0; last_tag = "R10"; end
    if (rec >= 0) exp_status = rec;
    if (nff != 0) exp_ff = 1;
    if (flip != 0) begin n = 15; last_tag = "R11"; end
    exp_st = n;
    @(negedge clk);
  endtask

  task automatic episode(input int ncyc);
    do_reset();
    for (int i = 0; i < ncyc; i++) step(i);
  endtask

  task automatic expect_end(input string tag, input int st, input int stat);
    chk({tag, " final state"}, state, st);
    chk({tag, " final status"}, status, stat);
  endtask

  initial begin
    void'($urandom(32'h1c5e_a7b3));
    rst_n = 1'b0;
    k_rma = 1'b1;
    rma   = 1'b1;
    rtok  = '0;
    drive_idle();
    @(negedge clk);

    knobs_default(); episode(120); expect_end("R8 clean success", 12, 1);
    knobs_default(); k_scrap = 100; episode(10); expect_end("R2 direct scrap", 13, 0);
    knobs_default(); k_hmode = 2; episode(120); expect_end("R7 upper half mismatch", 12, 2);
    knobs_default(); k_hmode = 1; episode(120); expect_end("R7 lower half mismatch", 12, 2);
    knobs_default(); k_ferr = 100; episode(120); expect_end("R6 flash error", 12, 4);
    knobs_default(); k_rma = 1'b0; episode(120); expect_end("R6 no wipe success", 12, 1);
    knobs_default(); k_full = 100; episode(40); expect_end("R4 counter full", 12, 3);
    knobs_default(); k_err = 100; k_hmode = 3; episode(80); expect_end("R4 counter program error", 12, 3);
    knobs_default(); k_ill = 100; episode(80); expect_end("R5 illegal transition", 12, 5);
    knobs_default(); k_perr = 100; episode(120); expect_end("R8 program error", 12, 6);
    knobs_default(); k_esc_at = 150; episode(160); expect_end("R10 escalate after success", 14, 1);
    knobs_default(); k_flip_at = 4; episode(30); expect_end("R11 fault to invalid", 15, 0);
    chk("R11 state_err after fault", state_err, 1);
    knobs_default(); k_flip_at = 3; k_esc_at = 20; episode(30); expect_end("R10 escalate from invalid", 14, 0);

    for (int e = 0; e < 150; e++) begin
      knobs_default();
      k_esc   = $urandom % 8;
      k_flip  = $urandom % 6;
      k_err   = $urandom % 15;
      k_ferr  = $urandom % 40;
      k_perr  = $urandom % 30;
      k_full  = $urandom % 10;
      k_ill   = $urandom % 15;
      k_scrap = $urandom % 10;
      k_miss  = $urandom % 40;
      k_hmode = 0;
      k_rma   = $urandom % 2;
      episode(70);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule